// File: doc/BRIEF.md
# Four-Wire Serial Configuration Register Port

This block is a serial configuration slave. A host selects it with an active-low chip select, sets a read/write strobe, and clocks sixteen bits per transfer over one serial data line: first an 8-bit address, then 8 data bits. On a write the byte lands in the addressed internal register. On a read the block turns the data line around once the address is complete and shifts the register contents back out. The bidirectional pad itself sits outside the block: the block sees the line as `sd_i` and drives it through `sd_o` gated by the enable `sd_oe`, where a low enable means high impedance.

Of the 32 register numbers, two (16 and 17 by default) each hold a pair of copies. Successive complete writes to such a number alternate between its two copies, so 34 physical registers sit behind 32 numbers. The highest register numbers (28 to 31 by default) are read-only and return bytes supplied on a status input. All writable contents, including the second copies, are presented in parallel on `cfg_o` for use by the surrounding logic.

The transfer logic runs on the externally supplied serial clock, which is at most 11 MHz and never faster than half the system clock. Raising chip select resets the transfer state at once, without any clock. A separate active-low reset clears the stored registers and the copy-select toggles. Chip select does not touch them.

Top module: `cfg_serial_port`

## Requirements
- R1: A transfer shifts 16 bits on `sd_i`, most significant bit first, each sampled on a rising `sclk` edge while `cs_n` is low: 8 address bits and then 8 data bits. On a write, the data byte is stored on the 16th rising edge and appears in the `cfg_o` slot of the addressed register.
- R2: The register number is address bits [6:2]. Address bits [1:0] and bit 7 have no effect on which register is accessed.
- R3: `rw_i` high selects a read and low selects a write. A read changes no stored register.
- R4: On a read, the block drives the data byte MSB first, changing `sd_o` on falling `sclk` edges. `sd_oe` is high for exactly the 8 data bit periods that follow the 8th rising edge and low during the address phase. It is never high during a write.
- R5: When `cs_n` is high, the bit count is reset at once and `sd_oe` is low. A transfer ended by `cs_n` rising before the 16th bit changes no register, and the next transfer starts cleanly from bit zero.
- R6: Each shadowed register number has a toggle. A complete write goes to copy 0 (`cfg_o` slot equal to the register number) when the toggle is 0, and to copy 1 when it is 1. The toggle then flips. Copy 1 of register 16 is `cfg_o` slot 32, and copy 1 of register 17 is slot 33. The two toggles are independent.
- R7: A read of a shadowed register number returns the copy written most recently. This is copy 1 while its toggle is 0, and copy 0 while its toggle is 1. A read does not flip the toggle.
- R8: Registers 28 to 31 are read-only. A read of register 28+k returns `sts_i[8k+7:8k]`. Writes to them have no effect, and their `cfg_o` slots are zero.
- R9: `rst_n` low clears every stored register and both toggles to zero, asynchronously. `cs_n` leaves both untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock supplied by the host |
| rst_n | input | 1 | Active-low asynchronous reset of registers and toggles |
| cs_n | input | 1 | Active-low chip select; high resets the transfer state asynchronously |
| rw_i | input | 1 | 1 = read, 0 = write |
| sd_i | input | 1 | Serial data in from the data pad |
| sd_o | output | 1 | Serial data out toward the data pad |
| sd_oe | output | 1 | Pad output enable; 0 = high impedance |
| sts_i | input | 32 | Read-only register values, byte k for register 28+k |
| cfg_o | output | 272 | Register contents, 8 bits per slot: slots 0-31 copy 0, slots 32-33 copy 1 of registers 16 and 17 |

## Verification
Writes and readbacks use bytes with distinct patterns: all zeros, all ones, alternating bits, and asymmetric values such as 0x81 and 0xA5. These catch reversed bit order, an off-by-one shift, and stuck data bits. Addresses are sent both clean and with the ignored bits set, to tell a correct decode from one that uses the wrong address bits. Shadowed registers get three writes in a row with readbacks between them, which separates the alternation order from the readback choice. Transfers cut at 12 and 15 bits, writes to read-only numbers, and a reset pulse confirm that none of these leaks into the stored state.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int unsigned CFGP_DATA_W  = 8;
   localparam int unsigned CFGP_ADDR_W  = 8;
   localparam int unsigned CFGP_IDX_LSB = 2;
   localparam int unsigned CFGP_IDX_W   = 5;

   // number of read-only registers at the top of the register space
   function automatic int unsigned ro_count(int unsigned idx_w, int unsigned ro_base);
      return (1 << idx_w) - ro_base;
   endfunction
endpackage

// File: rtl/cfgp_shift.sv
module cfgp_shift #(
   parameter int unsigned FRAME = 16,
   parameter int unsigned CNT_W = 5
) (
   input  logic             sclk,
   input  logic             clr,
   input  logic             rw_i,
   input  logic             sd_i,
   output logic [CNT_W-1:0] cnt,
   output logic [FRAME-1:0] sh,
   output logic             rw_q
);
   always_ff @(posedge sclk or posedge clr) begin
      if (clr) begin
         cnt  <= '0;
         sh   <= '0;
         rw_q <= 1'b0;
      end else if (cnt != CNT_W'(FRAME)) begin
         sh  <= {sh[FRAME-2:0], sd_i};
         cnt <= cnt + 1'b1;
         if (cnt == '0) rw_q <= rw_i;
      end
   end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned SHADOW_A = 16,
   parameter int unsigned SHADOW_B = 17,
   parameter int unsigned RO_BASE  = 28,
   localparam int unsigned NREG    = 1 << IDX_W,
   localparam int unsigned NRO     = NREG - RO_BASE,
   localparam int unsigned NSLOT   = NREG + 2
) (
   input  logic                    sclk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic [DATA_W-1:0]       rd_data,
   input  logic [NRO*DATA_W-1:0]   sts_i,
   output logic [NSLOT*DATA_W-1:0] cfg_o
);
   localparam int unsigned RO_W = (NRO > 1) ? $clog2(NRO) : 1;

   logic [DATA_W-1:0] prim   [NREG];
   logic [DATA_W-1:0] sec    [2];
   logic [DATA_W-1:0] sts_arr[NRO];
   logic [1:0]        tog;

   for (genvar k = 0; k < NRO; k++) begin : g_sts
      assign sts_arr[k] = sts_i[k*DATA_W +: DATA_W];
   end

   // copy 0 of every register number
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i >= RO_BASE) begin : g_ro
         assign prim[i] = '0;
      end else begin : g_rw
         logic              sel_ok;
         logic [DATA_W-1:0] q;
         if (i == SHADOW_A) begin : g_sa
            assign sel_ok = ~tog[0];
         end else if (i == SHADOW_B) begin : g_sb
            assign sel_ok = ~tog[1];
         end else begin : g_pl
            assign sel_ok = 1'b1;
         end
         always_ff @(posedge sclk or negedge rst_n) begin
            if (!rst_n)                                          q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i) && sel_ok)      q <= wr_data;
         end
         assign prim[i] = q;
      end
      assign cfg_o[i*DATA_W +: DATA_W] = prim[i];
   end

   // second copies and their toggles
   for (genvar s = 0; s < 2; s++) begin : g_shadow
      localparam int unsigned SI = (s == 0) ? SHADOW_A : SHADOW_B;
      logic              t;
      logic [DATA_W-1:0] q2;
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n) begin
            t  <= 1'b0;
            q2 <= '0;
         end else if (wr_en && wr_idx == IDX_W'(SI)) begin
            t <= ~t;
            if (t) q2 <= wr_data;
         end
      end
      assign tog[s] = t;
      assign sec[s] = q2;
      assign cfg_o[(NREG+s)*DATA_W +: DATA_W] = q2;
   end

   logic [IDX_W-1:0] ro_full;
   logic [RO_W-1:0]  ro_off;
   assign ro_full = rd_idx - IDX_W'(RO_BASE);
   assign ro_off  = ro_full[RO_W-1:0];

   always_comb begin
      rd_data = prim[rd_idx];
      if (rd_idx >= IDX_W'(RO_BASE))             rd_data = sts_arr[ro_off];
      else if (rd_idx == IDX_W'(SHADOW_A))       rd_data = tog[0] ? prim[rd_idx] : sec[0];
      else if (rd_idx == IDX_W'(SHADOW_B))       rd_data = tog[1] ? prim[rd_idx] : sec[1];
   end
endmodule

// File: rtl/cfgp_drive.sv
module cfgp_drive #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 5,
   localparam int unsigned FRAME = ADDR_W + DATA_W
) (
   input  logic              sclk,
   input  logic              clr,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              rw_q,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sd_o,
   output logic              sd_oe
);
   logic [DATA_W-1:0] dsh;

   always_ff @(negedge sclk or posedge clr) begin
      if (clr) begin
         dsh   <= '0;
         sd_oe <= 1'b0;
      end else if (cnt == CNT_W'(ADDR_W)) begin
         dsh   <= rd_data;
         sd_oe <= rw_q;
      end else if (cnt > CNT_W'(ADDR_W) && cnt < CNT_W'(FRAME)) begin
         dsh   <= {dsh[DATA_W-2:0], 1'b0};
      end else begin
         sd_oe <= 1'b0;
      end
   end

   assign sd_o = dsh[DATA_W-1];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
   import cfgp_pkg::*;
#(
   parameter int unsigned DATA_W   = CFGP_DATA_W,
   parameter int unsigned ADDR_W   = CFGP_ADDR_W,
   parameter int unsigned IDX_LSB  = CFGP_IDX_LSB,
   parameter int unsigned IDX_W    = CFGP_IDX_W,
   parameter int unsigned SHADOW_A = 16,
   parameter int unsigned SHADOW_B = 17,
   parameter int unsigned RO_BASE  = 28,
   localparam int unsigned NREG    = 1 << IDX_W,
   localparam int unsigned NSLOT   = NREG + 2,
   localparam int unsigned NRO     = ro_count(IDX_W, RO_BASE),
   localparam int unsigned FRAME   = ADDR_W + DATA_W,
   localparam int unsigned CNT_W   = $clog2(FRAME + 1)
) (
   input  logic                    sclk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    rw_i,
   input  logic                    sd_i,
   output logic                    sd_o,
   output logic                    sd_oe,
   input  logic [NRO*DATA_W-1:0]   sts_i,
   output logic [NSLOT*DATA_W-1:0] cfg_o
);
   if (IDX_LSB + IDX_W > ADDR_W) begin : g_bad_idx
      $error("register index does not fit in the address");
   end
   if (SHADOW_A == SHADOW_B) begin : g_bad_sh
      $error("shadowed register numbers must differ");
   end
   if (RO_BASE <= SHADOW_A || RO_BASE <= SHADOW_B || RO_BASE >= NREG) begin : g_bad_ro
      $error("read-only range must lie above the shadowed registers and inside the space");
   end
   if (DATA_W < 2 || ADDR_W < 2) begin : g_bad_w
      $error("field widths too small");
   end

   logic              clr;
   logic [CNT_W-1:0]  cnt;
   logic [FRAME-1:0]  sh;
   logic              rw_q;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;

   assign clr = cs_n | ~rst_n;

   cfgp_shift #(.FRAME(FRAME), .CNT_W(CNT_W)) u_shift (
      .sclk(sclk), .clr(clr), .rw_i(rw_i), .sd_i(sd_i),
      .cnt(cnt), .sh(sh), .rw_q(rw_q)
   );

   // on the last rising edge the address sits one bit below the top
   assign wr_addr = sh[FRAME-2 -: ADDR_W];
   assign wr_data = {sh[DATA_W-2:0], sd_i};
   assign wr_idx  = wr_addr[IDX_LSB +: IDX_W];
   assign wr_en   = ~cs_n & ~rw_q & (cnt == CNT_W'(FRAME - 1));
   assign rd_idx  = sh[IDX_LSB +: IDX_W];

   cfgp_bank #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .SHADOW_A(SHADOW_A),
      .SHADOW_B(SHADOW_B), .RO_BASE(RO_BASE)
   ) u_bank (
      .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
      .sts_i(sts_i), .cfg_o(cfg_o)
   );

   cfgp_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_drive (
      .sclk(sclk), .clr(clr), .cnt(cnt), .rw_q(rw_q),
      .rd_data(rd_data), .sd_o(sd_o), .sd_oe(sd_oe)
   );
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
   parameter int unsigned CFG_W = 272
) (
   input logic             sclk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             rw_i,
   input logic             sd_oe,
   input logic [CFG_W-1:0] cfg_o
);
   // R5: no drive while deselected
   p_hiz_idle_r5: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |-> !sd_oe);

   // R4: drive only during a read
   p_oe_read_r4: assert property (@(posedge sclk) disable iff (!rst_n)
      sd_oe |-> rw_i);

   // R3: a read leaves the stored registers alone
   p_read_keeps_r3: assert property (@(posedge sclk) disable iff (!rst_n)
      (rw_i && !cs_n) |=> $stable(cfg_o));

   // R5: nothing is stored while deselected
   p_idle_keeps_r5: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |=> $stable(cfg_o));
endmodule

bind cfg_serial_port cfgp_port_chk #(.CFG_W(NSLOT*DATA_W)) u_chk (
   .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .rw_i(rw_i),
   .sd_oe(sd_oe), .cfg_o(cfg_o)
);

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;
   logic         sclk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         rw_i = 1'b0;
   logic         sd_i = 1'b0;
   logic         sd_o, sd_oe;
   logic [31:0]  sts_i = 32'hDDCC_BBAA;
   logic [271:0] cfg_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] mdl [34];
   bit         mtog [2];

   cfg_serial_port uut (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .rw_i(rw_i), .sd_i(sd_i),
      .sd_o(sd_o), .sd_oe(sd_oe), .sts_i(sts_i), .cfg_o(cfg_o)
   );

   always #10 sclk = ~sclk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 34; i++) mdl[i] = 8'h00;
      mtog[0] = 0; mtog[1] = 0;
   endtask

   task automatic model_write(input logic [7:0] a, input logic [7:0] d);
      int n;
      n = int'(a[6:2]);
      if (n >= 28) return;
      if (n == 16 || n == 17) begin
         if (mtog[n-16]) mdl[32 + n - 16] = d;
         else            mdl[n] = d;
         mtog[n-16] = !mtog[n-16];
      end else mdl[n] = d;
   endtask

   function automatic logic [7:0] model_read(input logic [7:0] a);
      int n;
      n = int'(a[6:2]);
      if (n >= 28) return sts_i[(n-28)*8 +: 8];
      if (n == 16 || n == 17) return mtog[n-16] ? mdl[n] : mdl[32 + n - 16];
      return mdl[n];
   endfunction

   task automatic check_all(input string req);
      int bad;
      bad = 0;
      for (int i = 0; i < 34; i++) begin
         if (cfg_o[i*8 +: 8] !== mdl[i]) begin
            bad++;
            $display("FAIL %s: slot %0d actual %h expected %h", req, i, cfg_o[i*8 +: 8], mdl[i]);
         end
      end
      checks++;
      if (bad != 0) fails++;
   endtask

   // one transfer of nbits bits; q collects the read byte, oe_err counts enable mismatches
   task automatic xfer(input logic rw, input logic [7:0] a, input logic [7:0] d,
                       input int nbits, output logic [7:0] q, output int oe_err);
      logic exp_oe;
      q = 8'h00;
      oe_err = 0;
      @(negedge sclk);
      cs_n = 1'b0;
      rw_i = rw;
      for (int i = 0; i < nbits; i++) begin
         sd_i = (i < 8) ? a[7-i] : d[15-i];
         @(posedge sclk);
         #5;
         exp_oe = rw && (i >= 8);
         if (sd_oe !== exp_oe) oe_err++;
         if (i >= 8) q[15-i] = sd_o;
         @(negedge sclk);
      end
      cs_n = 1'b1;
      #1;
      if (sd_oe !== 1'b0) oe_err++;
   endtask

   task automatic wr(input string req, input logic [7:0] a, input logic [7:0] d);
      logic [7:0] q;
      int e;
      xfer(1'b0, a, d, 16, q, e);
      chk({req, " write oe"}, e, 0);
      model_write(a, d);
   endtask

   task automatic rd(input string req, input logic [7:0] a);
      logic [7:0] q;
      int e;
      xfer(1'b1, a, 8'h00, 16, q, e);
      chk({req, " read data"}, q, model_read(a));
      chk({req, " R4 read oe window"}, e, 0);
   endtask

   task automatic t_reset();
      model_reset();
      check_all("R9 reset state");
      chk("R5 idle hiz", sd_oe, 0);
   endtask

   task automatic t_basic();
      wr("R1", 8'h0C, 8'hA5);
      check_all("R1 write reg3");
      wr("R1", 8'h00, 8'hFF);
      wr("R1", 8'h04, 8'h81);
      wr("R1", 8'h08, 8'h55);
      check_all("R1 write patterns");
      rd("R1", 8'h0C);
      rd("R1", 8'h00);
      rd("R1", 8'h04);
      rd("R1", 8'h08);
   endtask

   task automatic t_addr_bits();
      wr("R2", 8'h97, 8'h3C);   // bit7 and bits1:0 set, register 5
      check_all("R2 ignored address bits");
      rd("R2", 8'h16);
      rd("R2", 8'h14);
   endtask

   task automatic t_read_keeps();
      rd("R3", 8'h0C);
      rd("R3", 8'h20);
      check_all("R3 read leaves registers");
   endtask

   task automatic t_abort();
      logic [7:0] q;
      int e;
      xfer(1'b0, 8'h1C, 8'hEE, 12, q, e);
      chk("R5 abort12 oe", e, 0);
      check_all("R5 abort after 12 bits");
      xfer(1'b0, 8'h1C, 8'hEE, 15, q, e);
      check_all("R5 abort after 15 bits");
      xfer(1'b1, 8'h0C, 8'h00, 11, q, e);
      chk("R5 aborted read oe", e, 0);
      wr("R5", 8'h1C, 8'h77);
      check_all("R5 clean restart");
      rd("R5", 8'h1C);
   endtask

   task automatic t_shadow();
      rd("R7", 8'h40);                 // toggle 0 -> copy 1 (zero)
      wr("R6", 8'h40, 8'h11);
      check_all("R6 first write copy0");
      rd("R7", 8'h40);
      rd("R7", 8'h40);                 // read does not flip toggle
      wr("R6", 8'h40, 8'h22);
      check_all("R6 second write copy1");
      rd("R7", 8'h40);
      wr("R6", 8'h40, 8'h33);
      check_all("R6 third write copy0");
      wr("R6", 8'h44, 8'h44);
      check_all("R6 reg17 independent");
      rd("R7", 8'h44);
      rd("R7", 8'h40);
   endtask

   task automatic t_readonly();
      rd("R8", 8'h70);
      rd("R8", 8'h7C);
      wr("R8", 8'h74, 8'h55);
      check_all("R8 write to read-only ignored");
      rd("R8", 8'h74);
      sts_i = 32'h1234_5678;
      rd("R8", 8'h78);
   endtask

   task automatic t_rst();
      @(negedge sclk);
      rst_n = 1'b0;
      @(negedge sclk);
      rst_n = 1'b1;
      model_reset();
      check_all("R9 reset clears");
      wr("R9", 8'h40, 8'h99);
      check_all("R9 toggle cleared");
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge sclk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge sclk);
      t_basic();
      t_addr_bits();
      t_read_keeps();
      t_abort();
      t_shadow();
      t_readonly();
      t_rst();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule